// File: doc/BRIEF.md
# Read-After-Write Stall Controller

This block decides when the front end of a five-stage in-order pipeline must freeze because the instruction waiting in the decode stage reads a register that an older instruction has not yet written back. It compares the two source indices held in the fetch/decode register against the destination indices of the three older instructions in the execute, memory and writeback stages. It then drives the enables that hold the program counter and the fetch/decode register, and inserts a bubble into the decode/execute register.

One input selects the stall policy. Without operand forwarding, any live writer downstream blocks the consumer until that writer has left writeback. With forwarding, only a load directly ahead of its consumer blocks it, and only for one cycle. A taken-branch flush input takes priority over any stall. To make the bubbles observable, the block contains a small control-only pipeline model: a PC, the fetch/decode register, and the control fields of the three later stages.

Top module: `raw_stall_unit`

## Requirements
- R1: After a synchronous reset the PC is 0, every pipeline control register holds a nop (all enables 0), pc_we and ifid_we are 1, and bubble is 0.
- R2: With fwd_en = 0, a consumer stalls while a nonzero source matches the destination of a writing instruction in the execute, memory or writeback stage. A dependent instruction directly behind its producer sees 3 stall cycles; with one independent instruction between them it sees 2; with two between it sees 1; with three between it sees 0.
- R3: Source B is compared exactly as source A is, and a match on B alone stalls just as a match on A does.
- R4: Register index 0 never causes a stall, whatever the producers write.
- R5: A producer's destination counts only when its register-write enable is 1. A store (register-write 0, memory-write 1) never causes a stall.
- R6: During a stall cycle pc_we = 0 and ifid_we = 0, the PC and fetch/decode register keep their values, bubble = 1, and on the next cycle the decode/execute register has register-write and memory-write both 0.
- R7: With fwd_en = 1, a stall happens only when the decode/execute instruction is a load (mem_rd = 1, reg_we = 1) whose destination equals a nonzero source of the decode instruction. This inserts exactly one bubble. An ALU producer directly ahead causes none, and a load with one instruction between causes none.
- R8: The stall is combinational. It is high in the first cycle the consumer sits in the fetch/decode register, which is two cycles after a directly preceding producer was presented to fetch. The bubble reaches decode/execute at the next edge.
- R9: When flush = 1, pc_we = 1, ifid_we = 1 and bubble = 1 even if a hazard is present. At the next edge the PC loads flush_pc and both the fetch/decode and the decode/execute registers become nops.
- R10: The PC advances by 4 on every edge with pc_we = 1, so after N cycles from reset, of which S stalled, the PC is 4*(N-S).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | Policy select: 0 = no forwarding, 1 = load-use only |
| flush | input | 1 | Taken-branch flush, overrides stall |
| flush_pc | input | PC_W | Redirect address loaded on flush |
| f_src_a | input | 3 | Fetched instruction source A index |
| f_src_b | input | 3 | Fetched instruction source B index |
| f_dst | input | 3 | Fetched instruction destination index |
| f_reg_we | input | 1 | Fetched instruction writes a register |
| f_mem_we | input | 1 | Fetched instruction writes memory |
| f_mem_rd | input | 1 | Fetched instruction is a load |
| pc | output | PC_W | Program counter |
| pc_we | output | 1 | PC update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| bubble | output | 1 | Nop inserted into decode/execute at next edge |
| idex_dst | output | 3 | Decode/execute destination index |
| idex_reg_we | output | 1 | Decode/execute register-write enable |
| idex_mem_we | output | 1 | Decode/execute memory-write enable |
| idex_mem_rd | output | 1 | Decode/execute load flag |

## Verification
The hardest situations to reach from the ports are a match found only in the writeback stage, and a flush that arrives in the very cycle a stall is already pending. For the first, the producer is separated from its consumer by two unrelated instructions, so exactly one stall cycle must come from the last stage alone. For the second, the bench presents a producer and a dependent store, waits for the stall to appear, and then raises flush in that same cycle. The store's memory-write enable shows whether the wrong-path instruction was cleared instead of being held.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
    localparam int NUM_REGS    = 8;
    localparam int REG_W       = $clog2(NUM_REGS);
    localparam int DOWN_STAGES = 3;

    typedef enum logic {
        POL_NOFWD   = 1'b0,
        POL_LOADUSE = 1'b1
    } policy_e;

    typedef struct packed {
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst;
        logic             reg_we;
        logic             mem_we;
        logic             mem_rd;
    } insn_t;

    localparam insn_t NOP = '0;

    // True when producer p will write register r and r is not the zero register
    function automatic logic writes_to(input insn_t p, input logic [REG_W-1:0] r);
        return p.reg_we && (p.dst == r) && (r != '0);
    endfunction
endpackage

// File: rtl/rsu_detect.sv
module rsu_detect
    import rsu_pkg::*;
#(
    parameter int STAGES = DOWN_STAGES
) (
    input  insn_t   consumer,
    input  insn_t   producers [STAGES],
    input  policy_e policy,
    output logic    hazard
);
    logic [STAGES-1:0] hit;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic match;
            assign match = writes_to(producers[s], consumer.src_a) ||
                           writes_to(producers[s], consumer.src_b);
            if (s == 0) begin : g_near
                // nearest producer: any writer without forwarding, loads only with it
                assign hit[s] = match && ((policy == POL_NOFWD) || producers[s].mem_rd);
            end else begin : g_far
                assign hit[s] = match && (policy == POL_NOFWD);
            end
        end
    endgenerate

    assign hazard = |hit;

    always_comb begin
        if (consumer.src_a == '0 && consumer.src_b == '0) begin
            // R4
            zero_src_chk: assert (!hazard);
        end
    end
endmodule

// File: rtl/rsu_pipe.sv
module rsu_pipe
    import rsu_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  insn_t           fetch,
    input  logic            hold,
    input  logic            squash,
    input  logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] pc,
    output insn_t           ifid,
    output insn_t           idex,
    output insn_t           exmem,
    output insn_t           memwb
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ifid  <= NOP;
            idex  <= NOP;
            exmem <= NOP;
            memwb <= NOP;
        end else begin
            if (squash)     pc <= redirect_pc;
            else if (!hold) pc <= pc + STEP;

            if (squash)     ifid <= NOP;
            else if (!hold) ifid <= fetch;

            idex  <= (hold || squash) ? NOP : ifid;
            exmem <= idex;
            memwb <= exmem;
        end
    end

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc));
    // R6
    ifid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(ifid));
    // R6
    bubble_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hold || squash) |=> (!idex.reg_we && !idex.mem_we));
    // R9
    redirect_chk: assert property (@(posedge clk) disable iff (rst)
        squash |=> (pc == $past(redirect_pc) && ifid == NOP));
endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit
    import rsu_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_en,
    input  logic             flush,
    input  logic [PC_W-1:0]  flush_pc,
    input  logic [REG_W-1:0] f_src_a,
    input  logic [REG_W-1:0] f_src_b,
    input  logic [REG_W-1:0] f_dst,
    input  logic             f_reg_we,
    input  logic             f_mem_we,
    input  logic             f_mem_rd,
    output logic [PC_W-1:0]  pc,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             bubble,
    output logic [REG_W-1:0] idex_dst,
    output logic             idex_reg_we,
    output logic             idex_mem_we,
    output logic             idex_mem_rd
);
    insn_t   fetch_i, ifid, idex, exmem, memwb;
    insn_t   prod [DOWN_STAGES];
    policy_e policy;
    logic    hazard, stall;

    always_comb begin
        fetch_i.src_a  = f_src_a;
        fetch_i.src_b  = f_src_b;
        fetch_i.dst    = f_dst;
        fetch_i.reg_we = f_reg_we;
        fetch_i.mem_we = f_mem_we;
        fetch_i.mem_rd = f_mem_rd;
    end

    assign prod[0] = idex;
    assign prod[1] = exmem;
    assign prod[2] = memwb;
    assign policy  = policy_e'(fwd_en);

    rsu_detect #(.STAGES(DOWN_STAGES)) u_detect (
        .consumer (ifid),
        .producers(prod),
        .policy   (policy),
        .hazard   (hazard)
    );

    // a taken branch wins: the held instruction is on the wrong path anyway
    assign stall   = hazard && !flush;
    assign pc_we   = !stall;
    assign ifid_we = !stall;
    assign bubble  = stall || flush;

    rsu_pipe #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .fetch      (fetch_i),
        .hold       (stall),
        .squash     (flush),
        .redirect_pc(flush_pc),
        .pc         (pc),
        .ifid       (ifid),
        .idex       (idex),
        .exmem      (exmem),
        .memwb      (memwb)
    );

    assign idex_dst    = idex.dst;
    assign idex_reg_we = idex.reg_we;
    assign idex_mem_we = idex.mem_we;
    assign idex_mem_rd = idex.mem_rd;

    // R1
    reset_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && idex == NOP && exmem == NOP && memwb == NOP));
    // R9
    flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (pc_we && ifid_we && bubble));
    // R7
    loaduse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && stall) |=> (!fwd_en || !stall));
endmodule

// File: tb/tb_raw_stall_unit.sv
`timescale 1ns/1ps
module tb_raw_stall_unit;
    import rsu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fwd_en = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_pc = '0;
    logic [2:0]  f_src_a = '0, f_src_b = '0, f_dst = '0;
    logic        f_reg_we = 1'b0, f_mem_we = 1'b0, f_mem_rd = 1'b0;
    logic [15:0] pc;
    logic        pc_we, ifid_we, bubble;
    logic [2:0]  idex_dst;
    logic        idex_reg_we, idex_mem_we, idex_mem_rd;

    int n_tests = 0;
    int n_fail  = 0;

    insn_t prog [8];
    int fb_cycle, fb_pcwe, fb_ifidwe, fb_pc, nx_pc, nx_rwe, nx_mwe;

    always #4 clk = ~clk;

    raw_stall_unit dut (
        .clk(clk), .rst(rst), .fwd_en(fwd_en), .flush(flush), .flush_pc(flush_pc),
        .f_src_a(f_src_a), .f_src_b(f_src_b), .f_dst(f_dst),
        .f_reg_we(f_reg_we), .f_mem_we(f_mem_we), .f_mem_rd(f_mem_rd),
        .pc(pc), .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble),
        .idex_dst(idex_dst), .idex_reg_we(idex_reg_we),
        .idex_mem_we(idex_mem_we), .idex_mem_rd(idex_mem_rd)
    );

    function automatic insn_t mk(input int a, input int b, input int d,
                                 input bit rwe, input bit mwe, input bit mrd);
        insn_t t;
        t.src_a  = REG_W'(a);
        t.src_b  = REG_W'(b);
        t.dst    = REG_W'(d);
        t.reg_we = rwe;
        t.mem_we = mwe;
        t.mem_rd = mrd;
        return t;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input insn_t i);
        f_src_a  = i.src_a;
        f_src_b  = i.src_b;
        f_dst    = i.dst;
        f_reg_we = i.reg_we;
        f_mem_we = i.mem_we;
        f_mem_rd = i.mem_rd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        flush = 1'b0;
        drive(NOP);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Presents prog[0..n-1] to fetch, re-presenting while held; counts stall cycles
    task automatic run_prog(input logic md, input int n, output int nb, output int ncyc);
        int ptr = 0;
        bit take;
        fwd_en = md;
        do_reset();
        nb = 0;
        fb_cycle = -1;
        ncyc = n + 8;
        for (int c = 0; c < n + 8; c++) begin
            drive(ptr < n ? prog[ptr] : NOP);
            #1;
            if (bubble) nb++;
            if (bubble && fb_cycle < 0) begin
                fb_cycle  = c;
                fb_pcwe   = int'(pc_we);
                fb_ifidwe = int'(ifid_we);
                fb_pc     = int'(pc);
            end else if (fb_cycle >= 0 && c == fb_cycle + 1) begin
                nx_pc  = int'(pc);
                nx_rwe = int'(idex_reg_we);
                nx_mwe = int'(idex_mem_we);
            end
            take = ifid_we;
            @(posedge clk);
            if (take) ptr++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        fwd_en = 1'b0;
        do_reset();
        #1;
        check("R1 pc", int'(pc), 0);
        check("R1 pc_we", int'(pc_we), 1);
        check("R1 ifid_we", int'(ifid_we), 1);
        check("R1 bubble", int'(bubble), 0);
        check("R1 idex_reg_we", int'(idex_reg_we), 0);
        check("R1 idex_mem_we", int'(idex_mem_we), 0);
    endtask

    // producer r3, then a store reading r3 on source B only
    task automatic t_adjacent_srcb();
        int nb, nc;
        prog[0] = mk(0, 0, 3, 1, 0, 0);
        prog[1] = mk(1, 3, 0, 0, 1, 0);
        run_prog(1'b0, 2, nb, nc);
        check("R2/R3 adjacent stalls", nb, 3);
        check("R8 stall cycle", fb_cycle, 2);
        check("R6 pc_we low", fb_pcwe, 0);
        check("R6 ifid_we low", fb_ifidwe, 0);
        check("R6 pc held", nx_pc, fb_pc);
        check("R6 idex reg_we cleared", nx_rwe, 0);
        check("R6 idex mem_we cleared", nx_mwe, 0);
        check("R10 pc count", int'(pc), 4 * (nc - nb));
    endtask

    task automatic t_distance();
        int nb, nc;
        insn_t p = mk(0, 0, 3, 1, 0, 0);
        insn_t x = mk(1, 2, 4, 1, 0, 0);
        insn_t c = mk(3, 0, 5, 1, 0, 0);
        prog[0] = p; prog[1] = x; prog[2] = c;
        run_prog(1'b0, 3, nb, nc);
        check("R2 distance 2", nb, 2);
        prog[0] = p; prog[1] = x; prog[2] = x; prog[3] = c;
        run_prog(1'b0, 4, nb, nc);
        check("R2 distance 3 writeback only", nb, 1);
        check("R10 pc count", int'(pc), 4 * (nc - nb));
        prog[0] = p; prog[1] = x; prog[2] = x; prog[3] = x; prog[4] = c;
        run_prog(1'b0, 5, nb, nc);
        check("R2 distance 4", nb, 0);
    endtask

    task automatic t_zero_and_nowrite();
        int nb, nc;
        prog[0] = mk(1, 2, 0, 1, 0, 0);
        prog[1] = mk(0, 0, 6, 1, 0, 0);
        run_prog(1'b0, 2, nb, nc);
        check("R4 zero register", nb, 0);
        prog[0] = mk(1, 2, 3, 0, 1, 0);
        prog[1] = mk(3, 3, 6, 1, 0, 0);
        run_prog(1'b0, 2, nb, nc);
        check("R5 store producer", nb, 0);
    endtask

    task automatic t_forward_mode();
        int nb, nc;
        insn_t ld = mk(2, 0, 3, 1, 0, 1);
        insn_t al = mk(1, 2, 3, 1, 0, 0);
        insn_t x  = mk(1, 2, 4, 1, 0, 0);
        insn_t c  = mk(6, 3, 5, 1, 0, 0);
        prog[0] = al; prog[1] = c;
        run_prog(1'b1, 2, nb, nc);
        check("R7 alu producer", nb, 0);
        prog[0] = ld; prog[1] = c;
        run_prog(1'b1, 2, nb, nc);
        check("R7 load-use one bubble", nb, 1);
        check("R8 load-use stall cycle", fb_cycle, 2);
        prog[0] = ld; prog[1] = x; prog[2] = c;
        run_prog(1'b1, 3, nb, nc);
        check("R7 load spaced", nb, 0);
        prog[0] = ld; prog[1] = c;
        run_prog(1'b0, 2, nb, nc);
        check("R2 load without forwarding", nb, 3);
    endtask

    task automatic t_flush();
        fwd_en = 1'b0;
        do_reset();
        drive(mk(0, 0, 3, 1, 0, 0));
        @(negedge clk);
        drive(mk(3, 0, 0, 0, 1, 0));
        @(negedge clk);
        drive(NOP);
        #1;
        check("R9 stall pending", int'(bubble), 1);
        flush = 1'b1;
        flush_pc = 16'h0100;
        #1;
        check("R9 pc_we forced", int'(pc_we), 1);
        check("R9 ifid_we forced", int'(ifid_we), 1);
        check("R9 bubble on flush", int'(bubble), 1);
        @(negedge clk);
        flush = 1'b0;
        #1;
        check("R9 pc redirected", int'(pc), 16'h0100);
        check("R9 no stall after flush", int'(bubble), 0);
        check("R9 store cleared", int'(idex_mem_we), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_adjacent_srcb();
        t_distance();
        t_zero_and_nowrite();
        t_forward_mode();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule